// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This peripheral provides a set of independent down-counting timer channels behind a small register window. Each channel has a reload register, a live count, a configuration register and a sticky expiry flag. An enabled channel counts down on every clock. When it expires at zero, it reloads itself and sets its flag. Each channel drives its own interrupt line when its flag is set and its interrupt is enabled. A global freeze bit stops every channel at once.

Any channel except the first can be linked to the channel below it. A linked channel steps once per expiry of its neighbour, so two channels together form a counter twice as wide. Software sets a period of P clocks by writing P-1 to the reload register. A new reload value written to a running channel takes effect at the next reload. To restart at once, software turns the channel off and on again.

Top module: `ptmr_top`

## Requirements
- R1: After reset every register reads 0, every interrupt output is low and no channel counts.
- R2: The global control word sits at address 0x000 with freeze at bit 1. Channel n occupies 0x100+0x10*n: reload at +0x0, count at +0x4, configuration at +0x8 (bit 0 run, bit 1 interrupt enable, bit 2 link) and status at +0xC (bit 0 flag). Unused bits and unmapped addresses read 0.
- R3: The cycle after the run bit is written from 0 to 1, the count is loaded from the reload register. The count decrements by one on each following clock.
- R4: A counting channel whose count is 0 takes the reload value and sets its flag on its next step, so one period is reload+1 steps.
- R5: Writing the reload register of a running channel leaves the count in progress alone, and the new value is used at the next reload. Clearing and then setting the run bit starts a fresh period from the new value.
- R6: Writing 1 to status bit 0 clears the flag and writing 0 leaves it alone. An expiry in the same cycle as a clear leaves the flag set.
- R7: A channel's interrupt output equals its flag ANDed with its interrupt-enable bit. The flag stays set while the channel is stopped.
- R8: A linked channel steps only in a cycle when the channel below it expires. Channel 0 ignores its link bit.
- R9: While freeze is set, no channel steps or expires and all counts hold. The start load of R3 still takes place.
- R10: The count register is read-only and shows the live count. A stopped channel holds its last count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (12) | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | CNT_W (32) | Write data |
| rdata_o | output | CNT_W (32) | Read data for addr_i, combinational |
| irq_o | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
A channel can expire in the same clock that software writes 1 to clear its flag. The bench catches this by stepping a reload-3 channel while its reference model predicts its next step. It issues the clear in exactly the cycle the model expects the count to wrap. The flag must then read 1 and the interrupt line must stay high. A second collision happens when the reload register is written in the same cycle as a wrap. The model expects the old value to be loaded, and the count reads are compared against that.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // register slot inside one channel window, selected by address bits [3:2]
   typedef enum logic [1:0] {
      SLOT_RELOAD = 2'd0,
      SLOT_COUNT  = 2'd1,
      SLOT_CFG    = 2'd2,
      SLOT_STATUS = 2'd3
   } ch_slot_e;

   localparam int CFG_W     = 3;
   localparam int CFG_RUN   = 0;
   localparam int CFG_IE    = 1;
   localparam int CFG_LINK  = 2;
   localparam int GLB_FRZ   = 1;
   localparam int ST_FLAG   = 0;
endpackage

// File: rtl/ptmr_decode.sv
module ptmr_decode #(
   parameter int ADDR_W    = 12,
   parameter int NUM_CH    = 4,
   parameter int GLB_ADDR  = 'h000,
   parameter int CH_BASE   = 'h100,
   parameter int CH_STRIDE = 'h10
) (
   input  logic [ADDR_W-1:0]   addr_i,
   output logic                glb_hit_o,
   output logic [NUM_CH-1:0]   ch_hit_o,
   output ptmr_pkg::ch_slot_e  slot_o
);
   localparam int STRIDE_LG = $clog2(CH_STRIDE);

   generate
      if (CH_STRIDE < 16 || (1 << STRIDE_LG) != CH_STRIDE)
         $error("CH_STRIDE must be a power of two of at least 16");
      if (CH_BASE % CH_STRIDE != 0)
         $error("CH_BASE must be aligned to CH_STRIDE");
      if (CH_BASE + CH_STRIDE * NUM_CH > (1 << ADDR_W))
         $error("channel windows exceed the address space");
   endgenerate

   assign glb_hit_o = (addr_i == ADDR_W'(GLB_ADDR));
   assign slot_o    = ptmr_pkg::ch_slot_e'(addr_i[3:2]);

   for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
      localparam logic [ADDR_W-1:0] LO = ADDR_W'(CH_BASE + CH_STRIDE * n);
      logic [ADDR_W-1:0] off;
      assign off         = addr_i - LO;
      assign ch_hit_o[n] = (addr_i >= LO) && (off < ADDR_W'(16)) && (off[1:0] == 2'b00);
   end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
   parameter int CNT_W = 32
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        frz_i,
   input  logic                        tick_i,
   input  logic                        wr_reload_i,
   input  logic                        wr_cfg_i,
   input  logic                        clr_flag_i,
   input  logic [CNT_W-1:0]            wdata_i,
   output logic [CNT_W-1:0]            reload_o,
   output logic [CNT_W-1:0]            count_o,
   output logic [ptmr_pkg::CFG_W-1:0]  cfg_o,
   output logic                        flag_o,
   output logic                        expire_o,
   output logic                        irq_o
);
   import ptmr_pkg::*;

   logic run, run_q, start, step;

   assign run      = cfg_o[CFG_RUN];
   assign start    = run & ~run_q;
   assign step     = run & run_q & ~frz_i & tick_i;
   assign expire_o = step & (count_o == '0);
   assign irq_o    = flag_o & cfg_o[CFG_IE];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q    <= 1'b0;
         reload_o <= '0;
         count_o  <= '0;
         cfg_o    <= '0;
         flag_o   <= 1'b0;
      end else begin
         run_q <= run;
         if (wr_reload_i) reload_o <= wdata_i;
         if (wr_cfg_i)    cfg_o    <= wdata_i[CFG_W-1:0];
         if (start)
            count_o <= reload_o;
         else if (step)
            count_o <= expire_o ? reload_o : count_o - 1'b1;
         if (expire_o)
            flag_o <= 1'b1;
         else if (clr_flag_i)
            flag_o <= 1'b0;
      end
   end

   // R4
   wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> (count_o == $past(reload_o)) && flag_o);
   // R6
   flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_flag_i && !expire_o) |=> !flag_o);
   // R10
   stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> $stable(count_o));
   // R9
   frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frz_i && !start) |=> $stable(count_o));
   // R8
   no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && run_q && !tick_i) |=> $stable(count_o));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
   parameter int ADDR_W    = 12,
   parameter int CNT_W     = 32,
   parameter int NUM_CH    = 4,
   parameter int CH_BASE   = 'h100,
   parameter int CH_STRIDE = 'h10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [CNT_W-1:0]  wdata_i,
   output logic [CNT_W-1:0]  rdata_o,
   output logic [NUM_CH-1:0] irq_o
);
   import ptmr_pkg::*;

   generate
      if (NUM_CH < 1 || NUM_CH > 64) $error("NUM_CH out of range");
      if (CNT_W < 8)                 $error("CNT_W must be at least 8");
   endgenerate

   logic                 glb_hit, frz;
   logic [NUM_CH-1:0]    ch_hit, expire, flag;
   ch_slot_e             slot;
   logic [CNT_W-1:0]     reload [NUM_CH];
   logic [CNT_W-1:0]     count  [NUM_CH];
   logic [CFG_W-1:0]     cfg    [NUM_CH];

   ptmr_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .GLB_ADDR('h000),
      .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
   ) u_dec (
      .addr_i(addr_i), .glb_hit_o(glb_hit), .ch_hit_o(ch_hit), .slot_o(slot)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              frz <= 1'b0;
      else if (wr_i && glb_hit) frz <= wdata_i[GLB_FRZ];
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic tick;
      if (n == 0) begin : g_head
         assign tick = 1'b1;
      end else begin : g_link
         assign tick = cfg[n][CFG_LINK] ? expire[n-1] : 1'b1;
      end

      ptmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .frz_i       (frz),
         .tick_i      (tick),
         .wr_reload_i (wr_i && ch_hit[n] && slot == SLOT_RELOAD),
         .wr_cfg_i    (wr_i && ch_hit[n] && slot == SLOT_CFG),
         .clr_flag_i  (wr_i && ch_hit[n] && slot == SLOT_STATUS && wdata_i[ST_FLAG]),
         .wdata_i     (wdata_i),
         .reload_o    (reload[n]),
         .count_o     (count[n]),
         .cfg_o       (cfg[n]),
         .flag_o      (flag[n]),
         .expire_o    (expire[n]),
         .irq_o       (irq_o[n])
      );
   end

   always_comb begin
      rdata_o = '0;
      if (glb_hit) rdata_o[GLB_FRZ] = frz;
      for (int n = 0; n < NUM_CH; n++) begin
         if (ch_hit[n]) begin
            unique case (slot)
               SLOT_RELOAD: rdata_o = reload[n];
               SLOT_COUNT:  rdata_o = count[n];
               SLOT_CFG:    rdata_o = CNT_W'(cfg[n]);
               SLOT_STATUS: rdata_o = CNT_W'(flag[n]);
            endcase
         end
      end
   end

   // R7
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o & ~flag) == '0);
   // R9
   frozen_no_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frz |-> (expire == '0));
endmodule

// File: tb/tb_ptmr_top.sv
`timescale 1ns/1ps
module tb_ptmr_top;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] irq;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   // behavioural reference state
   logic [31:0] m_ld [N];
   logic [31:0] m_cv [N];
   logic [N-1:0] m_en, m_ie, m_lk, m_fl, m_enq;
   logic         m_frz;

   ptmr_top dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   always #2.5 clk = ~clk;

   function automatic logic [11:0] cha(int n, int off);
      return 12'(32'h100 + 32'h10 * n + off);
   endfunction

   function automatic logic [31:0] m_read(logic [11:0] a);
      if (a == 12'h000) return {30'd0, m_frz, 1'b0};
      for (int n = 0; n < N; n++) begin
         if (a == cha(n, 0))  return m_ld[n];
         if (a == cha(n, 4))  return m_cv[n];
         if (a == cha(n, 8))  return {29'd0, m_lk[n], m_ie[n], m_en[n]};
         if (a == cha(n, 12)) return {31'd0, m_fl[n]};
      end
      return 32'd0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // one clock: compare irq, drive inputs, optionally compare read data, advance model
   task automatic cyc(logic w, logic [11:0] a, logic [31:0] d, string tag = "");
      logic [N-1:0] ex;
      logic [31:0]  ncv [N];
      logic [N-1:0] nfl;
      @(negedge clk);
      check("R7 irq", {28'd0, irq}, {28'd0, m_fl & m_ie});
      wr = w; addr = a; wdata = d;
      #1;
      if (!w && tag != "") check(tag, rdata, m_read(a));
      ex = '0;
      for (int n = 0; n < N; n++) begin
         logic st, tk, stp, clr;
         st  = m_en[n] && !m_enq[n];
         tk  = (n > 0 && m_lk[n]) ? ex[n-1] : 1'b1;
         stp = m_en[n] && m_enq[n] && !m_frz && tk;
         ex[n] = stp && (m_cv[n] == 0);
         ncv[n] = st ? m_ld[n] : (stp ? ((m_cv[n] == 0) ? m_ld[n] : m_cv[n] - 1) : m_cv[n]);
         clr = w && a == cha(n, 12) && d[0];
         nfl[n] = ex[n] ? 1'b1 : (clr ? 1'b0 : m_fl[n]);
      end
      @(posedge clk);
      m_enq = m_en;
      for (int n = 0; n < N; n++) begin
         m_cv[n] = ncv[n];
         if (w && a == cha(n, 0)) m_ld[n] = d;
         if (w && a == cha(n, 8)) begin
            m_en[n] = d[0]; m_ie[n] = d[1]; m_lk[n] = d[2];
         end
      end
      m_fl = nfl;
      if (w && a == 12'h000) m_frz = d[1];
   endtask

   task automatic wrt(logic [11:0] a, logic [31:0] d);
      cyc(1'b1, a, d);
   endtask

   task automatic watch(logic [11:0] a, int k, string tag);
      for (int i = 0; i < k; i++) cyc(1'b0, a, 32'd0, tag);
   endtask

   initial begin : watchdog
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      for (int n = 0; n < N; n++) begin m_ld[n] = '0; m_cv[n] = '0; end
      m_en = '0; m_ie = '0; m_lk = '0; m_fl = '0; m_enq = '0; m_frz = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset values
      cyc(1'b0, 12'h000, 0, "R1 glb");
      for (int n = 0; n < N; n++)
         for (int o = 0; o < 16; o += 4) cyc(1'b0, cha(n, o), 0, "R1 reg");

      // R2 map: reserved cfg bits, unmapped holes
      wrt(cha(3, 8), 32'hFFFF_FFF8);
      cyc(1'b0, cha(3, 8), 0, "R2 cfg reserved");
      cyc(1'b0, 12'h0F0, 0, "R2 unmapped");
      cyc(1'b0, 12'h140, 0, "R2 past last");
      cyc(1'b0, cha(1, 2), 0, "R2 unaligned");
      wrt(12'h000, 32'hFFFF_FFFF);
      cyc(1'b0, 12'h000, 0, "R2 glb");
      wrt(12'h000, 0);

      // R3 / R4 start and periodic wrap on channel 0
      wrt(cha(0, 0), 4);
      wrt(cha(0, 8), 3);
      watch(cha(0, 4), 14, "R3 R4 count");
      cyc(1'b0, cha(0, 12), 0, "R4 flag");

      // R6 write 0 ignored, write 1 clears
      wrt(cha(0, 12), 0);
      cyc(1'b0, cha(0, 12), 0, "R6 write0");
      wrt(cha(0, 12), 1);
      cyc(1'b0, cha(0, 12), 0, "R6 write1");

      // R5 reload change while running, then restart
      wrt(cha(0, 0), 9);
      watch(cha(0, 4), 16, "R5 count");
      wrt(cha(0, 8), 2);
      wrt(cha(0, 0), 6);
      wrt(cha(0, 8), 3);
      watch(cha(0, 4), 10, "R5 restart");

      // R10 stop holds count, count register ignores writes; R7 flag persists
      wrt(cha(0, 8), 2);
      watch(cha(0, 4), 4, "R10 hold");
      wrt(cha(0, 4), 32'h1234_5678);
      cyc(1'b0, cha(0, 4), 0, "R10 read-only");
      cyc(1'b0, cha(0, 12), 0, "R7 flag kept");
      wrt(cha(0, 8), 0);
      cyc(1'b0, cha(0, 12), 0, "R7 ie off");
      wrt(cha(0, 12), 1);

      // R9 freeze
      wrt(cha(1, 0), 7);
      wrt(cha(1, 8), 3);
      watch(cha(1, 4), 4, "R9 before");
      wrt(12'h000, 2);
      watch(cha(1, 4), 12, "R9 frozen");
      wrt(cha(2, 0), 5);
      wrt(cha(2, 8), 1);
      watch(cha(2, 4), 4, "R9 start load");
      wrt(12'h000, 0);
      watch(cha(1, 4), 10, "R9 resumed");
      wrt(cha(1, 8), 0);
      wrt(cha(2, 8), 0);

      // R8 chain channel 1 to channel 0; channel 0 link bit ignored
      wrt(cha(0, 0), 2);
      wrt(cha(1, 0), 3);
      wrt(cha(1, 8), 7);
      wrt(cha(0, 8), 5);
      watch(cha(1, 4), 30, "R8 linked");
      watch(cha(0, 4), 6, "R8 head");
      cyc(1'b0, cha(1, 12), 0, "R8 flag");
      wrt(cha(0, 8), 0);
      wrt(cha(1, 8), 0);

      // R6 collision: clear in the cycle channel 2 wraps
      wrt(cha(2, 12), 1);
      wrt(cha(2, 0), 3);
      wrt(cha(2, 8), 3);
      for (int i = 0; i < 20; i++) begin
         if (m_en[2] && m_enq[2] && !m_frz && m_cv[2] == 0) begin
            wrt(cha(2, 12), 1);
            cyc(1'b0, cha(2, 12), 0, "R6 collision");
            check("R6 collision flag", m_fl[2], 1);
            break;
         end
         cyc(1'b0, cha(2, 4), 0, "R4 ch2");
      end
      // R5 reload write in the wrap cycle: old value loaded
      for (int i = 0; i < 20; i++) begin
         if (m_cv[2] == 0 && m_enq[2]) begin
            wrt(cha(2, 0), 11);
            watch(cha(2, 4), 6, "R5 wrap write");
            break;
         end
         cyc(1'b0, cha(2, 4), 0, "R4 ch2");
      end

      watch(12'h000, 2, "R1 idle");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule